// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block generates the fetch address for a small microcontroller's program store. The program counter is not a binary counter. It is a shift register with linear feedback that moves one state per instruction. Above it sit a page register and a chapter register. The fetch address is the concatenation {chapter, page, counter}.

A page change is made in two stages. A load-page instruction, or a branch target page chosen in advance, is first written into a page buffer. The buffer reaches the page register only when a branch, call or return takes effect. A chapter buffer, which a dedicated strobe toggles, works the same way for the chapter register. A one-deep return register, guarded by a call latch, provides a single level of subroutine nesting.

The surrounding core supplies the timing. It drives a subcycle number from 0 to 5 for each instruction, the low opcode field, the decoded strobes and the ALU status flag. While the halt input is high, every register in the block keeps its value.

Top module: `pgseq_top`

## Requirements
- R1: While reset is asserted and after its release, the counter, chapter register, chapter buffer, chapter save and call latch are 0, and the page register and page buffer are all ones (0xF). The address output therefore reads {0, 0xF, 0} = 0x3C0.
- R2: In subcycle 4 the counter moves to {pc[4:0], fb}. In the general case fb is 1 when pc[5] equals pc[4], and 0 otherwise.
- R3: Two counter states override the feedback bit. State 0x1F steps to 0x3F (fb forced to 1), and state 0x3F steps to 0x3E (fb forced to 0).
- R4: The address output is loaded with {chapter[10], page[9:6], counter[5:0]} in subcycle 1 only. In every other subcycle it holds its value.
- R5: With branch strobe and status both 1 in subcycle 0, the counter takes the 6-bit opcode field and the chapter register takes the chapter buffer. The page register takes the page buffer only if the call latch is clear. With status 0 the branch has no effect.
- R6: With call strobe and status both 1 in subcycle 0, the counter takes the opcode field, the chapter register takes the chapter buffer, and the page buffer receives the page value from before the call. If the call latch was clear, the call also sets the latch, saves the counter and chapter, and loads the page register from the buffer. If the latch was already set, none of these three actions happens.
- R7: A return strobe in subcycle 0 always copies the page buffer into the page register, regardless of status. If the call latch is set, the return also restores the saved counter and chapter, and it clears the latch.
- R8: A load-page strobe in subcycle 2 writes the low 4 opcode bits into the page buffer in reversed order: opcode bit 0 becomes page bit 3, and opcode bit 3 becomes page bit 0.
- R9: A chapter-flip strobe in subcycle 2 complements the chapter buffer.
- R10: While halt is 1, no register of the block changes, and the address output is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| halt_i | input | 1 | Freezes all state while high |
| subcyc_i | input | 3 | Subcycle number 0..5 within the instruction |
| op_field_i | input | 6 | Low opcode field: branch/call target, low 4 bits give the page constant |
| br_i | input | 1 | Decoded conditional branch |
| call_i | input | 1 | Decoded conditional call |
| ret_i | input | 1 | Decoded return |
| ldp_i | input | 1 | Decoded load-page-buffer |
| chap_flip_i | input | 1 | Decoded complement of chapter buffer |
| status_i | input | 1 | ALU status flag qualifying branch and call |
| rom_addr_o | output | 11 | Program fetch address {chapter, page, counter} |

## Verification
The bench first walks the counter out of reset through the states 0x1F and 0x3F. A design that applies only the plain feedback rule would either stick at 0x3F or jump to 0x3E one instruction too early. It then checks the bit-reversed page load and a branch attempted with status low; a page that is not reversed, or a branch that moves the address anyway, shows up as a wrong address. Random runs nest calls while the latch is already set and return with no call pending. These runs catch a design that overwrites the return register or commits the page buffer when it should not. Random halt cycles catch any register that still moves while frozen.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

  typedef enum logic [2:0] {
    SC_BRANCH = 3'd0,
    SC_ADDR   = 3'd1,
    SC_LOAD   = 3'd2,
    SC_WAIT   = 3'd3,
    SC_STEP   = 3'd4,
    SC_DECODE = 3'd5
  } subcyc_e;

  typedef struct packed {
    logic take_br;
    logic take_call;
    logic do_ret;
    logic do_addr;
    logic do_ldp;
    logic do_flip;
    logic do_step;
  } seq_ctl_t;

endpackage

// File: rtl/pgseq_ctl.sv
module pgseq_ctl
  import pgseq_pkg::*;
(
  input  logic       halt_i,
  input  logic [2:0] subcyc_i,
  input  logic       br_i,
  input  logic       call_i,
  input  logic       ret_i,
  input  logic       ldp_i,
  input  logic       chap_flip_i,
  input  logic       status_i,
  output seq_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '0;
    if (!halt_i) begin
      case (subcyc_i)
        SC_BRANCH: begin
          if (ret_i)                   ctl_o.do_ret    = 1'b1;
          else if (call_i && status_i) ctl_o.take_call = 1'b1;
          else if (br_i && status_i)   ctl_o.take_br   = 1'b1;
        end
        SC_ADDR: ctl_o.do_addr = 1'b1;
        SC_LOAD: begin
          ctl_o.do_ldp  = ldp_i;
          ctl_o.do_flip = chap_flip_i;
        end
        SC_STEP: ctl_o.do_step = 1'b1;
        default: ctl_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/pgseq_pc.sv
module pgseq_pc
  import pgseq_pkg::*;
#(
  parameter int PC_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seq_ctl_t        ctl_i,
  input  logic            latch_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o
);

  localparam logic [PC_W-1:0] HALF_ONES = {1'b0, {(PC_W-1){1'b1}}};
  localparam logic [PC_W-1:0] ALL_ONES  = {PC_W{1'b1}};

  logic [PC_W-1:0] pc_q, pc_d, ret_q, ret_d;
  logic            en;

  function automatic logic [PC_W-1:0] lfsr_next(input logic [PC_W-1:0] v);
    logic fb;
    fb = (v[PC_W-1] == v[PC_W-2]);
    if (v == HALF_ONES)     fb = 1'b1;
    else if (v == ALL_ONES) fb = 1'b0;
    return {v[PC_W-2:0], fb};
  endfunction

  always_comb begin
    pc_d  = pc_q;
    ret_d = ret_q;
    if (ctl_i.do_ret) begin
      if (latch_i) pc_d = ret_q;
    end else if (ctl_i.take_call) begin
      if (!latch_i) ret_d = pc_q;
      pc_d = target_i;
    end else if (ctl_i.take_br) begin
      pc_d = target_i;
    end else if (ctl_i.do_step) begin
      pc_d = lfsr_next(pc_q);
    end
  end

  assign en = ctl_i.do_ret | ctl_i.take_call | ctl_i.take_br | ctl_i.do_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ret_q <= '0;
    end else if (en) begin
      pc_q  <= pc_d;
      ret_q <= ret_d;
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/pgseq_bank.sv
module pgseq_bank
  import pgseq_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int CHAP_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_ctl_t          ctl_i,
  input  logic              latch_i,
  input  logic [PAGE_W-1:0] konst_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [CHAP_W-1:0] chap_o
);

  logic [PAGE_W-1:0] page_q, page_d, pbuf_q, pbuf_d, konst_rev;
  logic [CHAP_W-1:0] chap_q, chap_d, cbuf_q, cbuf_d, csave_q, csave_d;
  logic              en;

  for (genvar i = 0; i < PAGE_W; i++) begin : g_rev
    assign konst_rev[i] = konst_i[PAGE_W-1-i];
  end

  always_comb begin
    page_d  = page_q;
    pbuf_d  = pbuf_q;
    chap_d  = chap_q;
    cbuf_d  = cbuf_q;
    csave_d = csave_q;
    if (ctl_i.do_ret) begin
      if (latch_i) chap_d = csave_q;
      page_d = pbuf_q;
    end else if (ctl_i.take_call) begin
      if (!latch_i) begin
        page_d  = pbuf_q;
        csave_d = chap_q;
      end
      chap_d = cbuf_q;
      pbuf_d = page_q;
    end else if (ctl_i.take_br) begin
      if (!latch_i) page_d = pbuf_q;
      chap_d = cbuf_q;
    end
    if (ctl_i.do_ldp)  pbuf_d = konst_rev;
    if (ctl_i.do_flip) cbuf_d = cbuf_q ^ CHAP_W'(1);
  end

  assign en = ctl_i.do_ret | ctl_i.take_call | ctl_i.take_br |
              ctl_i.do_ldp | ctl_i.do_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '1;
      pbuf_q  <= '1;
      chap_q  <= '0;
      cbuf_q  <= '0;
      csave_q <= '0;
    end else if (en) begin
      page_q  <= page_d;
      pbuf_q  <= pbuf_d;
      chap_q  <= chap_d;
      cbuf_q  <= cbuf_d;
      csave_q <= csave_d;
    end
  end

  assign page_o = page_q;
  assign chap_o = chap_q;

endmodule

// File: rtl/pgseq_top.sv
module pgseq_top
  import pgseq_pkg::*;
#(
  parameter int PC_W   = 6,
  parameter int PAGE_W = 4,
  parameter int CHAP_W = 1,
  localparam int AW    = CHAP_W + PAGE_W + PC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_i,
  input  logic [2:0]      subcyc_i,
  input  logic [PC_W-1:0] op_field_i,
  input  logic            br_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            ldp_i,
  input  logic            chap_flip_i,
  input  logic            status_i,
  output logic [AW-1:0]   rom_addr_o
);

  seq_ctl_t          ctl;
  logic [PC_W-1:0]   pc_w;
  logic [PAGE_W-1:0] page_w;
  logic [CHAP_W-1:0] chap_w;
  logic              latch_q, latch_d, latch_en;
  logic [AW-1:0]     addr_q;

  pgseq_ctl u_ctl (
    .halt_i, .subcyc_i, .br_i, .call_i, .ret_i, .ldp_i, .chap_flip_i,
    .status_i, .ctl_o(ctl)
  );

  pgseq_pc #(.PC_W(PC_W)) u_pc (
    .clk, .rst_n, .ctl_i(ctl), .latch_i(latch_q),
    .target_i(op_field_i), .pc_o(pc_w)
  );

  pgseq_bank #(.PAGE_W(PAGE_W), .CHAP_W(CHAP_W)) u_bank (
    .clk, .rst_n, .ctl_i(ctl), .latch_i(latch_q),
    .konst_i(op_field_i[PAGE_W-1:0]), .page_o(page_w), .chap_o(chap_w)
  );

  always_comb begin
    latch_d = latch_q;
    if (ctl.do_ret)         latch_d = 1'b0;
    else if (ctl.take_call) latch_d = 1'b1;
  end

  assign latch_en = ctl.do_ret | ctl.take_call;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 1'b0;
    else if (latch_en) latch_q <= latch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           addr_q <= {{CHAP_W{1'b0}}, {PAGE_W{1'b1}}, {PC_W{1'b0}}};
    else if (ctl.do_addr) addr_q <= {chap_w, page_w, pc_w};
  end

  assign rom_addr_o = addr_q;

endmodule

// File: rtl/pgseq_chk.sv
module pgseq_chk #(
  parameter int PC_W = 6,
  parameter int PAGE_W = 4,
  parameter int AW = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt_i,
  input logic [2:0]        subcyc_i,
  input logic              call_i,
  input logic              ret_i,
  input logic              status_i,
  input logic [PC_W-1:0]   pc_q,
  input logic [PAGE_W-1:0] page_q,
  input logic              latch_q,
  input logic [AW-1:0]     rom_addr_o
);

  localparam logic [PC_W-1:0] HALF_ONES = {1'b0, {(PC_W-1){1'b1}}};
  localparam logic [PC_W-1:0] ALL_ONES  = {PC_W{1'b1}};

  p_plain_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_i && subcyc_i == 3'd4 && pc_q != HALF_ONES && pc_q != ALL_ONES)
    |=> pc_q == {$past(pc_q[PC_W-2:0]), ($past(pc_q[PC_W-1]) == $past(pc_q[PC_W-2]))});

  p_forced_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_i && subcyc_i == 3'd4 && pc_q == HALF_ONES) |=> pc_q == ALL_ONES);

  p_forced_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_i && subcyc_i == 3'd4 && pc_q == ALL_ONES) |=> pc_q == (ALL_ONES - 1'b1));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (subcyc_i != 3'd1) |=> $stable(rom_addr_o));

  p_call_sets_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_i && subcyc_i == 3'd0 && !ret_i && call_i && status_i) |=> latch_q);

  p_ret_clears_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_i && subcyc_i == 3'd0 && ret_i) |=> !latch_q);

  p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> ($stable(pc_q) && $stable(page_q) && $stable(latch_q) && $stable(rom_addr_o)));

endmodule

bind pgseq_top pgseq_chk #(.PC_W(PC_W), .PAGE_W(PAGE_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .subcyc_i(subcyc_i),
  .call_i(call_i), .ret_i(ret_i), .status_i(status_i),
  .pc_q(pc_w), .page_q(page_w), .latch_q(latch_q), .rom_addr_o(rom_addr_o)
);

// File: tb/pgseq_top_bench.sv
`timescale 1ns/1ps
module pgseq_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt_i = 1'b0;
  logic [2:0]  subcyc_i = 3'd0;
  logic [5:0]  op_field_i = '0;
  logic        br_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, ldp_i = 1'b0;
  logic        chap_flip_i = 1'b0, status_i = 1'b0;
  logic [10:0] rom_addr_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  pgseq_top u_pgseq_top (
    .clk, .rst_n, .halt_i, .subcyc_i, .op_field_i, .br_i, .call_i, .ret_i,
    .ldp_i, .chap_flip_i, .status_i, .rom_addr_o
  );

  // bench reference state
  logic [5:0]  m_pc, m_ret;
  logic [3:0]  m_page, m_pbuf;
  logic        m_chap, m_cbuf, m_csave, m_latch;
  logic [10:0] m_addr, seen_addr;

  function automatic logic [5:0] ref_step(input logic [5:0] v);
    int b;
    if (v == 6'd31)      b = 1;
    else if (v == 6'd63) b = 0;
    else                 b = (((v >> 5) & 1) == ((v >> 4) & 1)) ? 1 : 0;
    return 6'((int'(v) * 2 + b) % 64);
  endfunction

  function automatic logic [3:0] ref_rev(input logic [3:0] k);
    return {k[0], k[1], k[2], k[3]};
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rom_addr actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = '0; m_ret = '0; m_page = 4'hF; m_pbuf = 4'hF;
    m_chap = 0; m_cbuf = 0; m_csave = 0; m_latch = 0;
    m_addr = 11'h3C0;
  endtask

  // one instruction: six subcycles; halt_mask bit s freezes subcycle s
  task automatic run_instr(input logic [5:0] op, input logic b, input logic c,
                           input logic r, input logic l, input logic f,
                           input logic st, input logic [5:0] halt_mask);
    logic [3:0] old_page;
    string tag;
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      subcyc_i = 3'(s); op_field_i = op; br_i = b; call_i = c; ret_i = r;
      ldp_i = l; chap_flip_i = f; status_i = st; halt_i = halt_mask[s];
      tag = "R4";
      if (!halt_mask[s]) begin
        case (s)
          0: begin
            if (r) begin
              tag = "R7";
              if (m_latch) begin m_pc = m_ret; m_chap = m_csave; m_latch = 0; end
              m_page = m_pbuf;
            end else if (c && st) begin
              tag = "R6";
              old_page = m_page;
              if (!m_latch) begin
                m_latch = 1; m_ret = m_pc; m_csave = m_chap; m_page = m_pbuf;
              end
              m_chap = m_cbuf; m_pbuf = old_page; m_pc = op;
            end else if (b && st) begin
              tag = "R5";
              if (!m_latch) m_page = m_pbuf;
              m_chap = m_cbuf; m_pc = op;
            end
          end
          1: m_addr = {m_chap, m_page, m_pc};
          2: begin
            if (l) begin m_pbuf = ref_rev(op[3:0]); tag = "R8"; end
            if (f) begin m_cbuf = ~m_cbuf; tag = "R9"; end
          end
          4: begin m_pc = ref_step(m_pc); tag = "R2"; end
          default: ;
        endcase
      end else begin
        tag = "R10";
      end
      @(posedge clk);
      #1;
      check(tag, rom_addr_o, m_addr);
      if (s == 1) seen_addr = rom_addr_o;
    end
    @(negedge clk);
    halt_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] expect_pc [8];
    void'($urandom(32'h5EED));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1", rom_addr_o, 11'h3C0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", rom_addr_o, 11'h3C0);

    // R2/R3: counter walk from zero through the two forced states
    expect_pc = '{6'h00, 6'h01, 6'h03, 6'h07, 6'h0F, 6'h1F, 6'h3F, 6'h3E};
    for (int i = 0; i < 8; i++) begin
      run_instr(6'h00, 0, 0, 0, 0, 0, 0, 6'h00);
      check((i >= 6) ? "R3" : "R2", seen_addr, {1'b0, 4'hF, expect_pc[i]});
    end

    // R8: page buffer takes the reversed nibble; R5: taken branch commits it
    run_instr(6'h01, 0, 0, 0, 1, 0, 0, 6'h00);
    run_instr(6'h05, 1, 0, 0, 0, 0, 1, 6'h00);
    check("R8", seen_addr, {1'b0, 4'h8, 6'h05});
    // R5: branch with status 0 leaves the counter to step (5 -> 0x0B)
    run_instr(6'h10, 1, 0, 0, 0, 0, 0, 6'h00);
    check("R5", seen_addr, {1'b0, 4'h8, 6'h0B});

    // R9/R6/R7: flip chapter buffer, call into chapter 1, return to caller
    run_instr(6'h00, 0, 0, 0, 0, 1, 0, 6'h00);
    run_instr(6'h22, 0, 1, 0, 0, 0, 1, 6'h00);
    check("R6", seen_addr, {1'b1, 4'h8, 6'h22});
    run_instr(6'h00, 0, 0, 1, 0, 0, 0, 6'h00);
    check("R7", seen_addr, m_addr);

    // R10: a whole instruction under halt changes nothing
    run_instr(6'h3A, 1, 0, 0, 1, 0, 1, 6'h3F);
    check("R10", rom_addr_o, m_addr);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int sel;
      logic [5:0] hm;
      sel = $urandom % 10;
      hm = 6'h00;
      for (int s = 0; s < 6; s++) hm[s] = (($urandom % 8) == 0);
      run_instr(6'($urandom), sel < 2, sel == 2 || sel == 3, sel == 4,
                sel == 5 || sel == 6, sel == 7, 1'($urandom), hm);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule